// File: doc/BRIEF.md
# DMA copy program generator

This block turns a memory-copy request into the instruction stream that a loop-capable DMA engine runs to carry out the copy. The request is a source address, a destination address, a byte count and two increment flags, one for the source and one for the destination. A one-cycle start strobe launches generation. The block then emits 32-bit instruction slots, one per accepted valid/ready handshake. A downstream packer or instruction memory consumes them. The block moves no data itself.

The program layout depends on the length. Large copies are covered by a nested loop over 16 KiB blocks. A further loop covers the remaining 64-byte bursts, and one short burst covers the last few words. Loop instructions appear only when their iteration count is above one. Each program can cover at most 4 MiB. A longer request is emitted as a series of programs, and the addresses advance between them according to the increment flags. A request with a misaligned address or length, or with a zero length, produces no program.

Top module: `dma_prog_gen`

## Requirements
- R1: A start while idle with any of `src_i[1:0]`, `dst_i[1:0]` or `len_i[1:0]` nonzero raises `err_o` for exactly the next cycle. No slot is emitted and `done_o` stays low.
- R2: A start while idle with an aligned zero length raises `done_o` for the next cycle and emits no slot.
- R3: Every program opens with four slots in this order: `0x000000BC`, the source address, `0x000002BC`, the destination address.
- R4: The channel-control slot pair is `0x000001BC` followed by a control word. For a burst of B beats the control word holds (B-1)&15 at bits 21:18 and again at bits 7:4, and the beat code 2 at bits 17:15 and again at bits 3:1. It is ORed with the attribute, which has the source-increment flag at bit 0 and the destination-increment flag at bit 14.
- R5: When a program is at least 64 bytes long, a 16-beat control pair follows the prologue. If the program has K = len>>14 blocks with K >= 1, the generator emits, in order: an outer loop start ((K-1)&0xFF)<<8|0x20 (only if K > 1), `0x0000FF22`, `0x04`, `0x08`, `0x0000023C`, and `0x00000638` (only if K > 1).
- R6: For M = (len>>6)&255 bursts with M >= 1, the generator emits an optional loop start ((M-1)&0xFF)<<8|0x20, then `0x04`, then `0x08`, then an optional loop end `0x00000238`. Both loop slots appear only when M > 1.
- R7: A remainder of W = (len&63)>>2 words with W >= 1 produces a control pair with B = W, then `0x04`, then `0x08`.
- R8: Every program closes with `0x13`, `0x34` and `0x00`, in that order.
- R9: A request of more than 4 MiB is split into successive programs of 4 MiB each, with the remainder in the last one. Between programs the source address grows by 4 MiB only when the source flag is set, and the destination address grows by 4 MiB only when the destination flag is set.
- R10: After reset `out_valid_o` is low. A slot that is offered but not accepted stays on `out_data_o`, with `out_valid_o` high, until it is accepted.
- R11: `done_o` pulses for one cycle, in the cycle after the final `0x00` slot of the last program is accepted. A start that arrives while `busy_o` is high has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| src_i | input | 32 | Source byte address |
| dst_i | input | 32 | Destination byte address |
| len_i | input | LEN_W | Byte count |
| src_inc_i | input | 1 | Source address increments |
| dst_inc_i | input | 1 | Destination address increments |
| out_ready_i | input | 1 | Consumer accepts a slot |
| out_valid_o | output | 1 | Slot offered |
| out_data_o | output | 32 | Instruction slot |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle alignment error pulse |

## Verification
The assertions assume that the consumer never relies on a slot changing while it stalls. They also assume that start strobes which arrive during a request are dropped rather than queued. The bench therefore fires an extra start in the middle of each stream, with different arguments, and checks that the expected slot list is still matched in full. Ready is driven both constantly high and pseudo-randomly, so the hold-while-stalled property is exercised. The lengths are chosen to hit each structural branch: a lone tail, a single burst with no loop, single and multiple blocks, an exact 4 MiB program, and multi-program requests with each increment flag set on its own.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int SLOT_W = 32;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [4:0] {
    SL_IDLE, SL_SAR_OP, SL_SAR_ARG, SL_DAR_OP, SL_DAR_ARG,
    SL_CCR_OP, SL_CCR_ARG,
    SL_BLK_LP0, SL_BLK_LP1, SL_BLK_LD, SL_BLK_ST, SL_BLK_END1, SL_BLK_END0,
    SL_BUR_LP0, SL_BUR_LD, SL_BUR_ST, SL_BUR_END0,
    SL_TAIL_OP, SL_TAIL_ARG, SL_TAIL_LD, SL_TAIL_ST,
    SL_WMB, SL_SEV, SL_END
  } slot_e;

  localparam slot_t OP_MOV_SRC = 32'h0000_00BC;
  localparam slot_t OP_MOV_CTL = 32'h0000_01BC;
  localparam slot_t OP_MOV_DST = 32'h0000_02BC;
  localparam slot_t OP_LOAD    = 32'h0000_0004;
  localparam slot_t OP_STORE   = 32'h0000_0008;
  localparam slot_t OP_WMB     = 32'h0000_0013;
  localparam slot_t OP_END     = 32'h0000_0000;
  localparam logic [4:0] EVT_ID     = 5'd0;
  localparam logic [2:0] BEAT_CODE  = 3'd2;  // 4-byte beats
  localparam logic [7:0] JUMP_INNER = 8'd2;
  localparam logic [7:0] JUMP_OUTER = 8'd6;
  localparam logic [8:0] INNER_ITER = 9'd256;

  function automatic slot_t loop_start(input logic [8:0] cnt, input logic ctr);
    logic [8:0] m;
    m = cnt - 9'd1;
    return {16'd0, m[7:0], 8'h20 | {6'd0, ctr, 1'b0}};
  endfunction

  function automatic slot_t loop_end(input logic [7:0] jump, input logic ctr);
    return {16'd0, jump, ctr ? 8'h3C : 8'h38};
  endfunction

  function automatic slot_t ctl_word(input logic [4:0] beats, input slot_t attr);
    logic [4:0] b;
    b = beats - 5'd1;
    return {10'd0, b[3:0], BEAT_CODE, 7'd0, b[3:0], BEAT_CODE, 1'b0} | attr;
  endfunction

  function automatic slot_t op_event(input logic [4:0] id);
    return {16'd0, id, 11'h034};
  endfunction
endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int LEN_W    = 32,
  parameter int CHUNK_LG = 22,
  parameter int BLOCK_LG = 14,
  parameter int BURST_LG = 6
) (
  input  logic [LEN_W-1:0]               rem_i,
  output logic                           more_o,
  output logic [CHUNK_LG-BLOCK_LG:0]     blocks_o,
  output logic [BLOCK_LG-BURST_LG-1:0]   bursts_o,
  output logic [BURST_LG-3:0]            tail_o
);
  localparam int CW = CHUNK_LG + 1;
  localparam logic [LEN_W-1:0] CHUNK_BYTES = LEN_W'(1) << CHUNK_LG;

  logic [CW-1:0] chunk;

  assign more_o   = rem_i > CHUNK_BYTES;
  assign chunk    = more_o ? CW'(CHUNK_BYTES) : rem_i[CW-1:0];
  assign blocks_o = chunk[CW-1:BLOCK_LG];
  assign bursts_o = chunk[BLOCK_LG-1:BURST_LG];
  assign tail_o   = chunk[BURST_LG-1:2];

  // R1
  always_comb begin
    rem_aligned_chk: assert (rem_i[1:0] == 2'b00);
  end
endmodule

// File: rtl/dma_slot_seq.sv
module dma_slot_seq import dma_pg_pkg::*; #(
  parameter int BLK_W  = 9,
  parameter int BUR_W  = 8,
  parameter int TAIL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              ready_i,
  input  slot_t             src_i,
  input  slot_t             dst_i,
  input  slot_t             attr_i,
  input  logic [BLK_W-1:0]  blocks_i,
  input  logic [BUR_W-1:0]  bursts_i,
  input  logic [TAIL_W-1:0] tail_i,
  output logic              valid_o,
  output slot_t             data_o,
  output logic              idle_o,
  output logic              chunk_done_o
);
  slot_e state_q, state_d, after_bur, bur_entry, blk_entry;
  logic blk_any, blk_multi, bur_multi;

  assign blk_any   = blocks_i != '0;
  assign blk_multi = blocks_i > BLK_W'(1);
  assign bur_multi = bursts_i > BUR_W'(1);

  always_comb begin
    after_bur = (tail_i != '0) ? SL_TAIL_OP : SL_WMB;
    if (bur_multi)             bur_entry = SL_BUR_LP0;
    else if (bursts_i != '0)   bur_entry = SL_BUR_LD;
    else                       bur_entry = after_bur;
    if (!blk_any)              blk_entry = bur_entry;
    else if (blk_multi)        blk_entry = SL_BLK_LP0;
    else                       blk_entry = SL_BLK_LP1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SL_IDLE:     state_d = SL_SAR_OP;
      SL_SAR_OP:   state_d = SL_SAR_ARG;
      SL_SAR_ARG:  state_d = SL_DAR_OP;
      SL_DAR_OP:   state_d = SL_DAR_ARG;
      SL_DAR_ARG:  state_d = (blk_any || bursts_i != '0) ? SL_CCR_OP : after_bur;
      SL_CCR_OP:   state_d = SL_CCR_ARG;
      SL_CCR_ARG:  state_d = blk_entry;
      SL_BLK_LP0:  state_d = SL_BLK_LP1;
      SL_BLK_LP1:  state_d = SL_BLK_LD;
      SL_BLK_LD:   state_d = SL_BLK_ST;
      SL_BLK_ST:   state_d = SL_BLK_END1;
      SL_BLK_END1: state_d = blk_multi ? SL_BLK_END0 : bur_entry;
      SL_BLK_END0: state_d = bur_entry;
      SL_BUR_LP0:  state_d = SL_BUR_LD;
      SL_BUR_LD:   state_d = SL_BUR_ST;
      SL_BUR_ST:   state_d = bur_multi ? SL_BUR_END0 : after_bur;
      SL_BUR_END0: state_d = after_bur;
      SL_TAIL_OP:  state_d = SL_TAIL_ARG;
      SL_TAIL_ARG: state_d = SL_TAIL_LD;
      SL_TAIL_LD:  state_d = SL_TAIL_ST;
      SL_TAIL_ST:  state_d = SL_WMB;
      SL_WMB:      state_d = SL_SEV;
      SL_SEV:      state_d = SL_END;
      SL_END:      state_d = SL_IDLE;
      default:     state_d = SL_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      SL_SAR_OP:   data_o = OP_MOV_SRC;
      SL_SAR_ARG:  data_o = src_i;
      SL_DAR_OP:   data_o = OP_MOV_DST;
      SL_DAR_ARG:  data_o = dst_i;
      SL_CCR_OP,
      SL_TAIL_OP:  data_o = OP_MOV_CTL;
      SL_CCR_ARG:  data_o = ctl_word(5'd16, attr_i);
      SL_TAIL_ARG: data_o = ctl_word(5'(tail_i), attr_i);
      SL_BLK_LP0:  data_o = loop_start(9'(blocks_i), 1'b0);
      SL_BLK_LP1:  data_o = loop_start(INNER_ITER, 1'b1);
      SL_BLK_LD,
      SL_BUR_LD,
      SL_TAIL_LD:  data_o = OP_LOAD;
      SL_BLK_ST,
      SL_BUR_ST,
      SL_TAIL_ST:  data_o = OP_STORE;
      SL_BLK_END1: data_o = loop_end(JUMP_INNER, 1'b1);
      SL_BLK_END0: data_o = loop_end(JUMP_OUTER, 1'b0);
      SL_BUR_LP0:  data_o = loop_start(9'(bursts_i), 1'b0);
      SL_BUR_END0: data_o = loop_end(JUMP_INNER, 1'b0);
      SL_WMB:      data_o = OP_WMB;
      SL_SEV:      data_o = op_event(EVT_ID);
      default:     data_o = OP_END;
    endcase
  end

  assign idle_o       = state_q == SL_IDLE;
  assign valid_o      = !idle_o;
  assign chunk_done_o = (state_q == SL_END) && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     state_q <= SL_IDLE;
    else if (idle_o ? go_i : ready_i) state_q <= state_d;
  end

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  // R11
  go_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> idle_o);
endmodule

// File: rtl/dma_prog_gen.sv
module dma_prog_gen import dma_pg_pkg::*; #(
  parameter int LEN_W    = 32,
  parameter int CHUNK_LG = 22,
  parameter int BLOCK_LG = 14,
  parameter int BURST_LG = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      src_i,
  input  logic [31:0]      dst_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             src_inc_i,
  input  logic             dst_inc_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [31:0]      out_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int BLK_W  = CHUNK_LG - BLOCK_LG + 1;
  localparam int BUR_W  = BLOCK_LG - BURST_LG;
  localparam int TAIL_W = BURST_LG - 2;
  localparam logic [LEN_W-1:0] LEN_STEP  = LEN_W'(1) << CHUNK_LG;
  localparam slot_t            ADDR_STEP = SLOT_W'(1) << CHUNK_LG;

  logic             busy_q, done_q, err_q, sinc_q, dinc_q;
  slot_t            src_q, dst_q, attr;
  logic [LEN_W-1:0] rem_q;
  logic             misaligned, start_ok, seq_idle, chunk_done, more, go;
  logic [BLK_W-1:0]  blocks;
  logic [BUR_W-1:0]  bursts;
  logic [TAIL_W-1:0] tail;

  assign misaligned = |{src_i[1:0], dst_i[1:0], len_i[1:0]};
  assign start_ok   = start_i && !busy_q && !misaligned && (len_i != '0);
  assign go         = start_ok || (busy_q && seq_idle);
  assign attr       = {17'd0, dinc_q, 13'd0, sinc_q};

  dma_chunk_calc #(
    .LEN_W(LEN_W), .CHUNK_LG(CHUNK_LG), .BLOCK_LG(BLOCK_LG), .BURST_LG(BURST_LG)
  ) u_calc (
    .rem_i(rem_q), .more_o(more), .blocks_o(blocks), .bursts_o(bursts), .tail_o(tail)
  );

  dma_slot_seq #(.BLK_W(BLK_W), .BUR_W(BUR_W), .TAIL_W(TAIL_W)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .ready_i(out_ready_i),
    .src_i(src_q), .dst_i(dst_q), .attr_i(attr),
    .blocks_i(blocks), .bursts_i(bursts), .tail_i(tail),
    .valid_o(out_valid_o), .data_o(out_data_o),
    .idle_o(seq_idle), .chunk_done_o(chunk_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      sinc_q <= 1'b0; dinc_q <= 1'b0;
      src_q <= '0; dst_q <= '0; rem_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_i && !busy_q) begin
        if (misaligned)          err_q  <= 1'b1;
        else if (len_i == '0)    done_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          src_q  <= src_i;
          dst_q  <= dst_i;
          rem_q  <= len_i;
          sinc_q <= src_inc_i;
          dinc_q <= dst_inc_i;
        end
      end
      if (chunk_done) begin
        if (more) begin
          rem_q <= rem_q - LEN_STEP;
          if (sinc_q) src_q <= src_q + ADDR_STEP;
          if (dinc_q) dst_q <= dst_q + ADDR_STEP;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rem_q  <= '0;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R1
  misalign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && misaligned |=> err_o && !out_valid_o && !done_o);

  // R2
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !misaligned && len_i == '0 |=> done_o && !out_valid_o);

  // R11
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o && !busy_o);

  // R11
  err_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_o, done_o}));
endmodule

// File: tb/tb_dma_prog_gen.sv
`timescale 1ns/1ps
module tb_dma_prog_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_i = '0, dst_i = '0, len_i = '0;
  logic        src_inc_i = 1'b0, dst_inc_i = 1'b0, out_ready_i = 1'b0;
  logic        out_valid_o, busy_o, done_o, err_o;
  logic [31:0] out_data_o;

  int checks = 0;
  int fails  = 0;
  int unsigned exp_q[$];

  always #4 clk = ~clk;

  dma_prog_gen dut (
    .clk_i(clk), .rst_ni, .start_i, .src_i, .dst_i, .len_i,
    .src_inc_i, .dst_inc_i, .out_ready_i,
    .out_valid_o, .out_data_o, .busy_o, .done_o, .err_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_ctl(input int unsigned beats, input int unsigned attr);
    int unsigned b;
    b = (beats - 1) & 15;
    exp_q.push_back(32'h1BC);
    exp_q.push_back((b << 18) | (2 << 15) | (b << 4) | (2 << 1) | attr);
  endtask

  task automatic build(input int unsigned s, input int unsigned d, input int unsigned len,
                       input bit si, input bit di);
    int unsigned rem, n, k, attr;
    rem  = len;
    attr = (si ? 1 : 0) | (di ? (1 << 14) : 0);
    while (rem > 0) begin
      n = (rem > (1 << 22)) ? (1 << 22) : rem;
      rem -= n;
      exp_q.push_back(32'hBC);  exp_q.push_back(s);
      exp_q.push_back(32'h2BC); exp_q.push_back(d);
      if (n >= 64) begin
        push_ctl(16, attr);
        k = n >> 14;
        if (k >= 1) begin
          if (k > 1) exp_q.push_back((((k - 1) & 255) << 8) | 32'h20);
          exp_q.push_back(32'hFF22);
          exp_q.push_back(4); exp_q.push_back(8);
          exp_q.push_back(32'h23C);
          if (k > 1) exp_q.push_back(32'h638);
          n = n & 16383;
        end
        k = n >> 6;
        if (k >= 1) begin
          if (k > 1) exp_q.push_back((((k - 1) & 255) << 8) | 32'h20);
          exp_q.push_back(4); exp_q.push_back(8);
          if (k > 1) exp_q.push_back(32'h238);
          n = n & 63;
        end
      end
      if (n >= 4) begin
        push_ctl(n >> 2, attr);
        exp_q.push_back(4); exp_q.push_back(8);
      end
      exp_q.push_back(32'h13); exp_q.push_back(32'h34); exp_q.push_back(0);
      if (si) s += (1 << 22);
      if (di) d += (1 << 22);
    end
  endtask

  task automatic kick(input int unsigned s, input int unsigned d, input int unsigned n,
                      input bit si, input bit di);
    src_i = s; dst_i = d; len_i = n; src_inc_i = si; dst_inc_i = di;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_prog(input string req, input int unsigned s, input int unsigned d,
                          input int unsigned n, input bit si, input bit di, input bit rnd);
    int iter;
    bit want_done, stall, rdy;
    int unsigned stall_d, e;
    iter = 0; want_done = 0; stall = 0; stall_d = 0;
    exp_q.delete();
    build(s, d, n, si, di);
    kick(s, d, n, si, di);
    forever begin
      if (want_done) begin
        chk(done_o === 1'b1, "R11", "done after final end", done_o, 1);
        break;
      end
      if (done_o) begin
        chk(1'b0, "R11", "early done", 1, 0);
        break;
      end
      if (stall)
        chk(out_valid_o && out_data_o == stall_d, "R10", "held slot", out_data_o, stall_d);
      rdy = rnd ? (($urandom % 4) != 0) : 1'b1;
      out_ready_i = rdy;
      if (iter == 5) begin
        start_i = 1'b1; src_i = 32'hDEAD0000; len_i = 32'd4;  // R11: ignored while busy
      end else start_i = 1'b0;
      if (out_valid_o && rdy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, req, "extra slot", out_data_o, 0);
          break;
        end
        e = exp_q.pop_front();
        chk(out_data_o == e, req, "slot", out_data_o, e);
        if (exp_q.size() == 0) want_done = 1;
      end
      stall   = out_valid_o && !rdy;
      stall_d = out_data_o;
      @(negedge clk);
      iter++;
      if (iter > 50000) break;
    end
    start_i = 1'b0;
    out_ready_i = 1'b0;
    chk(exp_q.size() == 0, req, "slots remaining", exp_q.size(), 0);
    chk(!out_valid_o && !busy_o, "R11", "idle after done", out_valid_o, 0);
  endtask

  task automatic run_bad(input int unsigned s, input int unsigned d, input int unsigned n);
    out_ready_i = 1'b1;
    kick(s, d, n, 1'b1, 1'b1);
    chk(err_o && !out_valid_o && !done_o, "R1", "error pulse", err_o, 1);
    @(negedge clk);
    chk(!err_o, "R1", "error one cycle", err_o, 0);
    for (int i = 0; i < 4; i++) begin
      chk(!out_valid_o && !done_o && !busy_o, "R1", "nothing emitted", out_valid_o, 0);
      @(negedge clk);
    end
    out_ready_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !done_o && !err_o && !busy_o, "R10", "reset state", out_valid_o, 0);

    run_bad(32'h1000_0001, 32'h2000_0000, 32'd64);
    run_bad(32'h1000_0000, 32'h2000_0002, 32'd64);
    run_bad(32'h1000_0000, 32'h2000_0000, 32'd66);

    kick(32'h1000_0000, 32'h2000_0000, 0, 1'b1, 1'b0);
    chk(done_o && !out_valid_o && !err_o, "R2", "zero length done", done_o, 1);
    @(negedge clk);
    chk(!done_o && !out_valid_o, "R2", "zero length quiet", out_valid_o, 0);

    run_prog("R3", 32'h1000_0000, 32'h2000_0040, 8, 1'b1, 1'b1, 1'b0);
    run_prog("R7", 32'h1000_0000, 32'h2000_0040, 4, 1'b0, 1'b0, 1'b0);
    run_prog("R7", 32'h1000_0100, 32'h2000_0000, 60, 1'b1, 1'b0, 1'b1);
    run_prog("R6", 32'h1000_0000, 32'h2000_0040, 64, 1'b1, 1'b1, 1'b0);
    run_prog("R6", 32'h1000_0000, 32'h2000_0040, 136, 1'b0, 1'b1, 1'b1);
    run_prog("R5", 32'h1000_0000, 32'h2000_0040, 16384, 1'b1, 1'b1, 1'b0);
    run_prog("R4", 32'h1000_0000, 32'h2000_0040, 3*16384 + 5*64 + 12, 1'b1, 1'b1, 1'b1);
    run_prog("R8", 32'h1000_0000, 32'h2000_0040, 255*64, 1'b0, 1'b0, 1'b1);
    run_prog("R5", 32'h0000_0000, 32'h4000_0000, 1 << 22, 1'b1, 1'b1, 1'b0);
    run_prog("R9", 32'h0100_0000, 32'h4000_0000, (1 << 22) + 8, 1'b1, 1'b0, 1'b0);
    run_prog("R9", 32'h0100_0000, 32'h4000_0000, 9 << 20, 1'b0, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule